// File: doc/BRIEF.md
# Cluster Cache Power-Up Sequencer

This block brings a shared cluster cache and its snoop-control arrays out of the unpowered state for the first time. It takes a single start pulse and steps through a fixed order of events. It closes the head-switch with the outputs clamped and held in reset. It releases the array clamps and turns on the array head-switches. Next it enables the cache clock in software mode and removes the head-switch clamp. It then releases the resets, with a debug-reset override held across the clamp release. Last, it requests the power rail and hands the clock to hardware control. Timed waits separate the phases. Their lengths are given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter.

If the head-switch-on status input is already high when start arrives, the cache is taken to be powered and the sequence is skipped. All control word writes go to one 32-bit register. That register is brought out whole, and each of its fields also drives a dedicated pin. The debug-reset override and the two clock controls are separate registers. A one-cycle done pulse marks the end of the sequence, and also the end of a skipped sequence.

Top module: `cache_pwrup_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first start, the control word, the override, both clock bits and done are all 0.
- R2: A start with hsOnSts high changes no output; done is high in the cycle directly after the start edge.
- R3: Otherwise, one cycle after the start edge is seen, the control word becomes 0x0010D700: head-switch clamp (bit 8), enable (bit 9), reset (bit 10), system reset (bit 12), snoop array clamp (bit 14), cache array clamp (bit 15), and count 16 in bits 27:16.
- R4: The debug-reset override rises one cycle after the first write and stays high through the first three waits.
- R5: After a wait of 2 µs, bits 14 and 15 clear (word 0x00101700). On the next cycle the cache array head-switch (bit 0) and the snoop array head-switch (bit 1) set (word 0x00101703).
- R6: After a further 2 µs the clock control becomes 01 (bit 0 enable, bit 1 hardware control). On the next cycle the head-switch clamp clears (word 0x00101603).
- R7: After a further 2 µs the override drops. On the next cycle bits 10 and 12 clear together (word 0x00100203).
- R8: After a further 54 µs the rail-on request (bit 28) sets (word 0x10100203). On the next cycle the clock control becomes 11 and stays enabled.
- R9: done is a single-cycle pulse, issued in the same cycle as the switch to hardware clock control.
- R10: A start pulse while the sequence is running, including in the done cycle, has no effect and yields no extra done.
- R11: The pins cacheArrHs, snoopArrHs, hsClamp, hsEnable, hsReset, sysReset, snoopArrClamp, cacheArrClamp and railOnReq always equal control word bits 0, 1, 8, 9, 10, 12, 14, 15 and 28.
- R12: A new start after a full sequence runs again from the first write. The clock control goes back to 01 at the clock-enable step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to run the power-up sequence |
| hsOnSts | input | 1 | Head-switch-on status (status word bit 9) |
| ctlWord | output | 32 | Mirror of the cache power control word |
| cacheArrHs | output | 1 | Cache array head-switch on |
| snoopArrHs | output | 1 | Snoop array head-switch on |
| hsClamp | output | 1 | Head-switch output clamp |
| hsEnable | output | 1 | Head-switch enable |
| hsReset | output | 1 | Head-switch domain reset |
| sysReset | output | 1 | Cluster system reset |
| snoopArrClamp | output | 1 | Snoop array clamp |
| cacheArrClamp | output | 1 | Cache array clamp |
| railOnReq | output | 1 | Power-rail-on request |
| dbgRstOvr | output | 1 | Debug-reset override |
| clkCtl | output | 2 | Clock control: bit 0 enable, bit 1 hardware control |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting edges from the one that samples start (edge 0), with S = 2·CYC_PER_US and L = 54·CYC_PER_US, the results arrive as follows. The first write lands at edge 1 and the override at edge 2. The clamp release lands at 3+S and the head-switches at 4+S. The clock enable lands at 5+2S and the clamp removal at 6+2S. The override drop lands at 7+3S and the reset release at 8+3S. The rail request lands at 9+3S+L, and the hardware clock and done at 10+3S+L. A skipped start shows done right after edge 0. The bench samples every output at the falling edge after each rising edge and compares it against a bench function of that edge offset. It also counts done pulses across each window, so stray start pulses that should be ignored are caught.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // control word field positions; the neighbour power logic decodes these
  localparam int B_ARR_HS     = 0;
  localparam int B_SNP_HS     = 1;
  localparam int B_HS_CLAMP   = 8;
  localparam int B_HS_EN      = 9;
  localparam int B_HS_RST     = 10;
  localparam int B_SYS_RST    = 12;
  localparam int B_SNP_CLAMP  = 14;
  localparam int B_ARR_CLAMP  = 15;
  localparam int CNT_LSB      = 16;
  localparam int CNT_W        = 12;
  localparam int B_RAIL       = 28;

  // clock control bits
  localparam int C_ENABLE     = 0;
  localparam int C_HW         = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_OVR_ON, ST_WAIT_A, ST_CLAMP_REL, ST_ARR_HS,
    ST_WAIT_B, ST_CLK_SW, ST_HSC_REL, ST_WAIT_C, ST_OVR_OFF, ST_RST_REL,
    ST_WAIT_D, ST_RAIL, ST_CLK_HW, ST_FINISH
  } seq_state_t;

  typedef struct packed {
    logic loadInit;
    logic ovrSet;
    logic arrClampRel;
    logic arrHsSet;
    logic clkSwOn;
    logic hsClampRel;
    logic ovrClr;
    logic resetRel;
    logic railSet;
    logic clkHwOn;
  } seq_strobe_t;

  function automatic logic [31:0] initWord(input int hsCount);
    logic [31:0] w;
    w = '0;
    w[B_HS_CLAMP]  = 1'b1;
    w[B_HS_EN]     = 1'b1;
    w[B_HS_RST]    = 1'b1;
    w[B_SYS_RST]   = 1'b1;
    w[B_SNP_CLAMP] = 1'b1;
    w[B_ARR_CLAMP] = 1'b1;
    w[CNT_LSB +: CNT_W] = CNT_W'(hsCount);
    return w;
  endfunction

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 216,
  parameter int TMR_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             hsOnSts,
  input  logic             tmrZero,
  output logic             tmrLoad,
  output logic [TMR_W-1:0] tmrVal,
  output seq_strobe_t      stb,
  output logic             busy,
  output logic             done
);
  localparam logic [TMR_W-1:0] SHORT_LOAD = TMR_W'(SHORT_CYC - 1);
  localparam logic [TMR_W-1:0] LONG_LOAD  = TMR_W'(LONG_CYC - 1);

  seq_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    tmrLoad   = 1'b0;
    tmrVal    = SHORT_LOAD;
    unique case (state)
      ST_IDLE:      if (startPulse) nextState = hsOnSts ? ST_FINISH : ST_INIT;
      ST_INIT:      begin stb.loadInit = 1'b1; nextState = ST_OVR_ON; end
      ST_OVR_ON:    begin stb.ovrSet = 1'b1; tmrLoad = 1'b1; nextState = ST_WAIT_A; end
      ST_WAIT_A:    if (tmrZero) nextState = ST_CLAMP_REL;
      ST_CLAMP_REL: begin stb.arrClampRel = 1'b1; nextState = ST_ARR_HS; end
      ST_ARR_HS:    begin stb.arrHsSet = 1'b1; tmrLoad = 1'b1; nextState = ST_WAIT_B; end
      ST_WAIT_B:    if (tmrZero) nextState = ST_CLK_SW;
      ST_CLK_SW:    begin stb.clkSwOn = 1'b1; nextState = ST_HSC_REL; end
      ST_HSC_REL:   begin stb.hsClampRel = 1'b1; tmrLoad = 1'b1; nextState = ST_WAIT_C; end
      ST_WAIT_C:    if (tmrZero) nextState = ST_OVR_OFF;
      ST_OVR_OFF:   begin stb.ovrClr = 1'b1; nextState = ST_RST_REL; end
      ST_RST_REL:   begin
                      stb.resetRel = 1'b1; tmrLoad = 1'b1; tmrVal = LONG_LOAD;
                      nextState = ST_WAIT_D;
                    end
      ST_WAIT_D:    if (tmrZero) nextState = ST_RAIL;
      ST_RAIL:      begin stb.railSet = 1'b1; nextState = ST_CLK_HW; end
      ST_CLK_HW:    begin stb.clkHwOn = 1'b1; nextState = ST_FINISH; end
      ST_FINISH:    nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
endmodule

// File: rtl/cps_datapath.sv
module cps_datapath
  import cps_pkg::*;
#(
  parameter int HS_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t stb,
  output logic [31:0] ctlWord,
  output logic        dbgRstOvr,
  output logic [1:0]  clkCtl
);
  localparam logic [31:0] INIT_WORD = initWord(HS_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlWord   <= '0;
      dbgRstOvr <= 1'b0;
      clkCtl    <= '0;
    end else begin
      if (stb.loadInit) ctlWord <= INIT_WORD;
      if (stb.arrClampRel) begin
        ctlWord[B_SNP_CLAMP] <= 1'b0;
        ctlWord[B_ARR_CLAMP] <= 1'b0;
      end
      if (stb.arrHsSet) begin
        ctlWord[B_ARR_HS] <= 1'b1;
        ctlWord[B_SNP_HS] <= 1'b1;
      end
      if (stb.hsClampRel) ctlWord[B_HS_CLAMP] <= 1'b0;
      if (stb.resetRel) begin
        ctlWord[B_HS_RST]  <= 1'b0;
        ctlWord[B_SYS_RST] <= 1'b0;
      end
      if (stb.railSet) ctlWord[B_RAIL] <= 1'b1;
      if (stb.ovrSet) dbgRstOvr <= 1'b1;
      if (stb.ovrClr) dbgRstOvr <= 1'b0;
      if (stb.clkSwOn) begin
        clkCtl[C_ENABLE] <= 1'b1;
        clkCtl[C_HW]     <= 1'b0;
      end
      if (stb.clkHwOn) begin
        clkCtl[C_ENABLE] <= 1'b1;
        clkCtl[C_HW]     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_pwrup_seq.sv
module cache_pwrup_seq
  import cps_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int SHORT_US   = 2,
  parameter int LONG_US    = 54,
  parameter int HS_COUNT   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        hsOnSts,
  output logic [31:0] ctlWord,
  output logic        cacheArrHs,
  output logic        snoopArrHs,
  output logic        hsClamp,
  output logic        hsEnable,
  output logic        hsReset,
  output logic        sysReset,
  output logic        snoopArrClamp,
  output logic        cacheArrClamp,
  output logic        railOnReq,
  output logic        dbgRstOvr,
  output logic [1:0]  clkCtl,
  output logic        done
);
  localparam int SHORT_CYC = CYC_PER_US * SHORT_US;
  localparam int LONG_CYC  = CYC_PER_US * LONG_US;
  localparam int TMR_W     = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;

  seq_strobe_t      stb;
  logic             tmrLoad;
  logic [TMR_W-1:0] tmrVal;
  logic             tmrZero;
  logic             busy;

  cps_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .TMR_W(TMR_W)) ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .hsOnSts(hsOnSts),
    .tmrZero(tmrZero), .tmrLoad(tmrLoad), .tmrVal(tmrVal), .stb(stb),
    .busy(busy), .done(done)
  );

  cps_timer #(.W(TMR_W)) timer (
    .clk(clk), .rstN(rstN), .load(tmrLoad), .loadVal(tmrVal), .zero(tmrZero)
  );

  cps_datapath #(.HS_COUNT(HS_COUNT)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlWord(ctlWord),
    .dbgRstOvr(dbgRstOvr), .clkCtl(clkCtl)
  );

  assign cacheArrHs    = ctlWord[B_ARR_HS];
  assign snoopArrHs    = ctlWord[B_SNP_HS];
  assign hsClamp       = ctlWord[B_HS_CLAMP];
  assign hsEnable      = ctlWord[B_HS_EN];
  assign hsReset       = ctlWord[B_HS_RST];
  assign sysReset      = ctlWord[B_SYS_RST];
  assign snoopArrClamp = ctlWord[B_SNP_CLAMP];
  assign cacheArrClamp = ctlWord[B_ARR_CLAMP];
  assign railOnReq     = ctlWord[B_RAIL];
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startPulse,
  input logic        hsOnSts,
  input logic        busy,
  input logic        done,
  input logic [31:0] ctlWord,
  input logic        dbgRstOvr,
  input logic [1:0]  clkCtl
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && hsOnSts) |=> (done && $stable(ctlWord) && $stable(clkCtl) && $stable(dbgRstOvr))); // R2
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && !hsOnSts) |=> ##1 (ctlWord == 32'h0010D700)); // R3
  AST_HS_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlWord[0]) |-> (!ctlWord[14] && !ctlWord[15] && dbgRstOvr)); // R5
  AST_CLAMP_REL_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlWord[8]) |-> (clkCtl == 2'b01 && ctlWord[0] && ctlWord[1])); // R6
  AST_OVR_BEFORE_RST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlWord[10]) |-> (!dbgRstOvr && !$past(dbgRstOvr) && !ctlWord[12])); // R7
  AST_RAIL_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlWord[28]) |-> (!ctlWord[10] && !ctlWord[12] && !ctlWord[8])); // R8
  AST_HW_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    clkCtl[1] |-> clkCtl[0]); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && busy && !done) |=> busy); // R10
  AST_START_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && done) |=> !busy); // R10
endmodule

bind cache_pwrup_seq cps_checker chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .hsOnSts(hsOnSts),
  .busy(busy), .done(done), .ctlWord(ctlWord), .dbgRstOvr(dbgRstOvr),
  .clkCtl(clkCtl)
);

// File: tb/cache_pwrup_seq_test.sv
`timescale 1ns/1ps
module cache_pwrup_seq_test;
  localparam int CPU = 4;
  localparam int SW  = 2 * CPU;
  localparam int LW  = 54 * CPU;
  localparam int FIN = 10 + 3 * SW + LW;
  localparam logic [31:0] W_INIT  = 32'h0010D700;
  localparam logic [31:0] W_CREL  = 32'h00101700;
  localparam logic [31:0] W_HS    = 32'h00101703;
  localparam logic [31:0] W_HSC   = 32'h00101603;
  localparam logic [31:0] W_RST   = 32'h00100203;
  localparam logic [31:0] W_RAIL  = 32'h10100203;

  typedef struct packed { logic [31:0] word; logic dbg; logic [1:0] clk; } snap_t;

  logic clk = 1'b0;
  logic rstN, startPulse, hsOnSts;
  logic [31:0] ctlWord;
  logic cacheArrHs, snoopArrHs, hsClamp, hsEnable, hsReset, sysReset;
  logic snoopArrClamp, cacheArrClamp, railOnReq, dbgRstOvr, done;
  logic [1:0] clkCtl;
  int total = 0;
  int bad = 0;
  snap_t prev;

  always #2.5 clk = ~clk;

  cache_pwrup_seq #(.CYC_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .hsOnSts(hsOnSts),
    .ctlWord(ctlWord), .cacheArrHs(cacheArrHs), .snoopArrHs(snoopArrHs),
    .hsClamp(hsClamp), .hsEnable(hsEnable), .hsReset(hsReset), .sysReset(sysReset),
    .snoopArrClamp(snoopArrClamp), .cacheArrClamp(cacheArrClamp),
    .railOnReq(railOnReq), .dbgRstOvr(dbgRstOvr), .clkCtl(clkCtl), .done(done)
  );

  function automatic snap_t expAt(int m, snap_t p, bit skip);
    snap_t e = p;
    if (skip) return e;
    if (m >= 1)              e.word = W_INIT;
    if (m >= 3 + SW)         e.word = W_CREL;
    if (m >= 4 + SW)         e.word = W_HS;
    if (m >= 6 + 2*SW)       e.word = W_HSC;
    if (m >= 8 + 3*SW)       e.word = W_RST;
    if (m >= 9 + 3*SW + LW)  e.word = W_RAIL;
    if (m >= 2)              e.dbg = 1'b1;
    if (m >= 7 + 3*SW)       e.dbg = 1'b0;
    if (m >= 5 + 2*SW)       e.clk = 2'b01;
    if (m >= 10 + 3*SW + LW) e.clk = 2'b11;
    return e;
  endfunction

  function automatic string wordTag(int m, bit skip);
    if (skip)           return "R2";
    if (m <= 2 + SW)    return "R3";
    if (m <= 5 + 2*SW)  return "R5";
    if (m <= 7 + 3*SW)  return "R6";
    if (m <= 8 + 3*SW + LW) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkPins();
    chk("R11", "pins",
        {23'd0, railOnReq, cacheArrClamp, snoopArrClamp, sysReset, hsReset, hsEnable,
         hsClamp, snoopArrHs, cacheArrHs},
        {23'd0, ctlWord[28], ctlWord[15], ctlWord[14], ctlWord[12], ctlWord[10],
         ctlWord[9], ctlWord[8], ctlWord[1], ctlWord[0]});
  endtask

  task automatic runOnce(bit skip, bit noise);
    snap_t base = prev;
    snap_t e;
    int dones = 0;
    int last = skip ? 0 : FIN;
    @(negedge clk);
    hsOnSts = skip;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int m = 0; m <= last + 3; m++) begin
      if (m > 0) @(negedge clk);
      e = expAt(m, base, skip);
      chk(wordTag(m, skip), "ctlWord", ctlWord, e.word);
      chk(skip ? "R2" : ((m < 7 + 3*SW) ? "R4" : "R7"), "dbgRstOvr", {31'd0, dbgRstOvr}, {31'd0, e.dbg});
      chk(skip ? "R2" : ((m < 9 + 3*SW + LW) ? "R6" : "R8"), "clkCtl", {30'd0, clkCtl}, {30'd0, e.clk});
      chk(skip ? "R2" : "R9", "done", {31'd0, done}, {31'd0, (m == last)});
      checkPins();
      if (!skip && base.clk == 2'b11 && m == 5 + 2*SW)
        chk("R12", "clkCtl rerun", {30'd0, clkCtl}, 32'd1);
      if (done) dones++;
      startPulse = (noise && m <= last) ? (($urandom % 3) == 0) : 1'b0;
      hsOnSts = $urandom % 2;
    end
    startPulse = 1'b0;
    chk(noise ? "R10" : "R9", "done count", dones, 1);
    prev = expAt(FIN + 100, base, skip);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'h1F2E3D4C);
    rstN = 1'b0;
    startPulse = 1'b0;
    hsOnSts = 1'b0;
    prev = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ctlWord in reset", ctlWord, 32'd0);
    chk("R1", "misc in reset", {28'd0, dbgRstOvr, clkCtl, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ctlWord after reset", ctlWord, 32'd0);
    chk("R1", "misc after reset", {28'd0, dbgRstOvr, clkCtl, done}, 32'd0);
    checkPins();

    runOnce(1'b1, 1'b0);   // skip from reset state, R2
    runOnce(1'b0, 1'b0);   // first full sequence
    runOnce(1'b0, 1'b1);   // rerun with stray starts, R12 and R10
    runOnce(1'b1, 1'b1);   // skip after power-up, start in done cycle, R2
    for (int k = 0; k < 6; k++) begin
      repeat ($urandom % 5) @(negedge clk);
      runOnce(($urandom % 3) == 0, $urandom % 2);
    end
    repeat (4) @(negedge clk);
    chk("R10", "idle ctlWord stable", ctlWord, prev.word);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule